// File: doc/BRIEF.md
# TDM Slot Error Status Unit

This unit sits beside the serializer of a time-division multiplexed serial port. In that port, transmit data, receive data and control data each occupy a configurable slot of a frame. The unit checks continuously whether two of the three slot assignments claim the same slot. It also checks whether a new frame sync arrives while the serializer is still busy with the previous frame. Each condition is latched in a sticky status flag. Software clears a flag by writing 1 to it.

A slot clash must not corrupt the line. While the slot error flag is set, the unit withdraws the permission to drive the transmit data pin and the permission to sample the receive data pin. It does this without changing the transmit or receive enables, which stay under software control. An early frame sync only raises its flag, and the serializer keeps moving whatever slots it can. A registered interrupt combines the two flags through per-flag enable bits held in a small write-only register.

Top module: `tdm_slot_err_status`

## Requirements
- R1: When at least one of tx_en or rx_en is 1, and two valid slot assignments among transmit, receive and control carry the same 5-bit index, sa_err is 1 after the next clock edge.
- R2: An assignment whose valid bit is 0 takes no part in the comparison, and valid assignments with distinct indices leave sa_err at 0.
- R3: txd_drive_en equals tx_en and rxd_sample_en equals rx_en, except while sa_err is 1, when both are 0. Clearing sa_err restores both without any change to tx_en or rx_en.
- R4: While tx_en and rx_en are both 0, neither flag becomes set, whatever the slot configuration or frame sync activity.
- R5: A write with wr_addr = 0 clears sa_err where wr_data[0] is 1 and fs_err where wr_data[1] is 1. A 0 bit in the write leaves its flag unchanged.
- R6: If a set condition and a write-1 clear of the same flag occur in the same cycle, the flag is 1 afterwards.
- R7: fs_err is set one edge after a rising edge of fsync that is sampled while frame_busy is 1 and the port is enabled. A rising edge of fsync sampled while frame_busy is 0 does not set it.
- R8: fs_err has no effect on txd_drive_en or rxd_sample_en.
- R9: A write with wr_addr = 1 loads the interrupt enables: wr_data[0] for the slot error and wr_data[1] for the frame sync error. irq is a register that, one edge later, equals the OR of each flag ANDed with its enable.
- R10: After reset, sa_err, fs_err, irq and both interrupt enables are 0.
- R11: A frame sync held high counts once. After fs_err has been cleared while fsync stays high and frame_busy stays 1, fs_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the control register |
| rx_en | input | 1 | Receive enable from the control register |
| txd_slot_vld | input | 1 | Transmit data slot assignment valid |
| txd_slot_idx | input | 5 | Transmit data slot index |
| rxd_slot_vld | input | 1 | Receive data slot assignment valid |
| rxd_slot_idx | input | 5 | Receive data slot index |
| ctl_slot_vld | input | 1 | Control data slot assignment valid |
| ctl_slot_idx | input | 5 | Control data slot index |
| fsync | input | 1 | Frame sync; its rising edge marks a frame start |
| frame_busy | input | 1 | High while the serializer is still moving slots of the current frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the status flags, 1 selects the interrupt enables |
| wr_data | input | 2 | Bit 0 refers to the slot error, bit 1 to the frame sync error |
| sa_err | output | 1 | Sticky slot assignment clash flag |
| fs_err | output | 1 | Sticky early frame sync flag |
| irq | output | 1 | Registered combined interrupt |
| txd_drive_en | output | 1 | Permission for the serializer to drive the transmit data pin |
| rxd_sample_en | output | 1 | Permission for the serializer to sample the receive data pin |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each.
- A clash hidden behind a cleared valid bit: a design that compares the indices alone would raise sa_err.
- A clash present while both enables are off: an unqualified design would latch sa_err.
- A write-1 clear in the same cycle as a persisting clash: a design where the clear wins would drop sa_err for one cycle and open the data pins.
- A frame sync held high across a clear: a design that detects the level instead of the edge would set fs_err again at once.
- A write of 0 to the status location: a design that writes the flags straight from the bus would lose them.
- The one-cycle interrupt lag and the per-flag masking: a design that is off by a cycle in either would miscompare.

// File: rtl/tdm_err_pkg.sv
package tdm_err_pkg;
    localparam int SLOT_IDX_W = 5;
    localparam int NUM_ASG    = 3;
    localparam int NUM_FLAG   = 2;
    localparam int FLAG_SA    = 0;
    localparam int FLAG_FS    = 1;
    localparam logic ADDR_STAT = 1'b0;
    localparam logic ADDR_IE   = 1'b1;

    typedef struct packed {
        logic                  vld;
        logic [SLOT_IDX_W-1:0] idx;
    } slot_asg_t;
endpackage

// File: rtl/tdm_slot_overlap.sv
module tdm_slot_overlap #(
    parameter int N_ASG = 3,
    parameter int IDX_W = 5
) (
    input  logic [N_ASG-1:0]       asg_vld,
    input  logic [N_ASG*IDX_W-1:0] asg_idx,
    output logic                   clash
);
    localparam int N_PAIR = N_ASG * N_ASG;

    logic [N_PAIR-1:0] pair_hit;

    // every ordered pair i<j compares; the rest tie off
    for (genvar i = 0; i < N_ASG; i++) begin : g_row
        for (genvar j = 0; j < N_ASG; j++) begin : g_col
            if (j > i) begin : g_cmp
                assign pair_hit[i*N_ASG+j] = asg_vld[i] & asg_vld[j] &
                    (asg_idx[i*IDX_W +: IDX_W] == asg_idx[j*IDX_W +: IDX_W]);
            end else begin : g_off
                assign pair_hit[i*N_ASG+j] = 1'b0;
            end
        end
    end

    assign clash = |pair_hit;
endmodule

// File: rtl/tdm_fsync_mon.sv
module tdm_fsync_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic frame_busy,
    input  logic active,
    output logic early_fs
);
    typedef struct packed {
        logic fs_prev;
    } mon_st_t;

    mon_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.fs_prev = fsync;
        early_fs     = active & fsync & ~st_q.fs_prev & frame_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tdm_err_regs.sv
module tdm_err_regs
    import tdm_err_pkg::*;
#(
    parameter int N_FLAG = NUM_FLAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] set_req,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [N_FLAG-1:0] wr_data,
    output logic [N_FLAG-1:0] flags,
    output logic              irq
);
    typedef struct packed {
        logic [N_FLAG-1:0] flags;
        logic [N_FLAG-1:0] ie;
        logic              irq;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_addr == ADDR_STAT)
            st_d.flags = st_q.flags & ~wr_data;
        if (wr_en && wr_addr == ADDR_IE)
            st_d.ie = wr_data;
        // a set applied after the clear wins a same-cycle collision
        st_d.flags = st_d.flags | set_req;
        st_d.irq   = |(st_q.flags & st_q.ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign irq   = st_q.irq;
endmodule

// File: rtl/tdm_slot_err_status.sv
module tdm_slot_err_status
    import tdm_err_pkg::*;
#(
    parameter int IDX_W = SLOT_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             txd_slot_vld,
    input  logic [IDX_W-1:0] txd_slot_idx,
    input  logic             rxd_slot_vld,
    input  logic [IDX_W-1:0] rxd_slot_idx,
    input  logic             ctl_slot_vld,
    input  logic [IDX_W-1:0] ctl_slot_idx,
    input  logic             fsync,
    input  logic             frame_busy,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [1:0]       wr_data,
    output logic             sa_err,
    output logic             fs_err,
    output logic             irq,
    output logic             txd_drive_en,
    output logic             rxd_sample_en
);
    localparam int N_ASG = NUM_ASG;

    logic [N_ASG-1:0]       asg_vld;
    logic [N_ASG*IDX_W-1:0] asg_idx;
    logic                   clash;
    logic                   early_fs;
    logic                   active;
    logic [NUM_FLAG-1:0]    set_req;
    logic [NUM_FLAG-1:0]    flags;

    assign active  = tx_en | rx_en;
    assign asg_vld = {ctl_slot_vld, rxd_slot_vld, txd_slot_vld};
    assign asg_idx = {ctl_slot_idx, rxd_slot_idx, txd_slot_idx};

    tdm_slot_overlap #(.N_ASG(N_ASG), .IDX_W(IDX_W)) u_overlap (
        .asg_vld (asg_vld),
        .asg_idx (asg_idx),
        .clash   (clash)
    );

    tdm_fsync_mon u_fsmon (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .frame_busy (frame_busy),
        .active     (active),
        .early_fs   (early_fs)
    );

    always_comb begin
        set_req          = '0;
        set_req[FLAG_SA] = active & clash;
        set_req[FLAG_FS] = early_fs;
    end

    tdm_err_regs #(.N_FLAG(NUM_FLAG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .flags   (flags),
        .irq     (irq)
    );

    assign sa_err        = flags[FLAG_SA];
    assign fs_err        = flags[FLAG_FS];
    assign txd_drive_en  = tx_en & ~sa_err;
    assign rxd_sample_en = rx_en & ~sa_err;
endmodule

// File: rtl/tdm_err_chk.sv
module tdm_err_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             rx_en,
    input logic             txd_slot_vld,
    input logic [IDX_W-1:0] txd_slot_idx,
    input logic             rxd_slot_vld,
    input logic [IDX_W-1:0] rxd_slot_idx,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [1:0]       wr_data,
    input logic             sa_err,
    input logic             fs_err,
    input logic             irq,
    input logic             txd_drive_en,
    input logic             rxd_sample_en
);
    AST_TXRX_CLASH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_en || rx_en) && txd_slot_vld && rxd_slot_vld && txd_slot_idx == rxd_slot_idx) |=> sa_err); // R1
    AST_PINS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        sa_err |-> (!txd_drive_en && !rxd_sample_en)); // R3
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en && !sa_err && !fs_err) |=> (!sa_err && !fs_err)); // R4
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_err && !(wr_en && wr_addr == 1'b0 && wr_data[0])) |=> sa_err); // R5
    AST_FS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_err && !(wr_en && wr_addr == 1'b0 && wr_data[1])) |=> fs_err); // R5
    AST_FS_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_err && !sa_err) |-> (txd_drive_en == tx_en && rxd_sample_en == rx_en)); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sa_err || fs_err)); // R9
endmodule

bind tdm_slot_err_status tdm_err_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tdm_slot_err_status_test.sv
`timescale 1ns/1ps
module tdm_slot_err_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 0, rx_en = 0;
    logic       txd_slot_vld = 0, rxd_slot_vld = 0, ctl_slot_vld = 0;
    logic [4:0] txd_slot_idx = '0, rxd_slot_idx = '0, ctl_slot_idx = '0;
    logic       fsync = 0, frame_busy = 0;
    logic       wr_en = 0, wr_addr = 0;
    logic [1:0] wr_data = '0;
    logic       sa_err, fs_err, irq, txd_drive_en, rxd_sample_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        string      req;
        logic [4:0] exp;
    } item_t;
    item_t sb_q[$];
    item_t mon_it;
    logic [4:0] obs;

    always #2 clk = ~clk;

    tdm_slot_err_status uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .txd_slot_vld(txd_slot_vld), .txd_slot_idx(txd_slot_idx),
        .rxd_slot_vld(rxd_slot_vld), .rxd_slot_idx(rxd_slot_idx),
        .ctl_slot_vld(ctl_slot_vld), .ctl_slot_idx(ctl_slot_idx),
        .fsync(fsync), .frame_busy(frame_busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sa_err(sa_err), .fs_err(fs_err), .irq(irq),
        .txd_drive_en(txd_drive_en), .rxd_sample_en(rxd_sample_en)
    );

    // driver: one clock edge, expected outputs {irq,fs,sa,txg,rxg} after it
    task automatic cyc(input string req, input logic [4:0] exp);
        @(posedge clk);
        sb_q.push_back('{req: req, exp: exp});
        #2;
    endtask

    task automatic slots(input logic tv, input logic [4:0] ti,
                         input logic rv, input logic [4:0] ri,
                         input logic cv, input logic [4:0] ci);
        txd_slot_vld = tv; txd_slot_idx = ti;
        rxd_slot_vld = rv; rxd_slot_idx = ri;
        ctl_slot_vld = cv; ctl_slot_idx = ci;
    endtask

    task automatic wr(input logic a, input logic [1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    // monitor: pops and compares shortly after each edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            mon_it = sb_q.pop_front();
            obs = {irq, fs_err, sa_err, txd_drive_en, rxd_sample_en};
            total++;
            if (obs !== mon_it.exp) begin
                bad++;
                $display("FAIL %s: got %b expected %b ({irq,fs,sa,txg,rxg})",
                         mon_it.req, obs, mon_it.exp);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cyc("R10 reset state", 5'b00000);

        tx_en = 1; rx_en = 1;
        slots(1, 5'd3, 1, 5'd4, 1, 5'd5);
        cyc("R2 distinct slots", 5'b00011);
        slots(1, 5'd3, 1, 5'd4, 0, 5'd3);
        cyc("R2 invalid ctl ignored", 5'b00011);

        tx_en = 0; rx_en = 0;
        slots(1, 5'd3, 1, 5'd4, 1, 5'd3);
        cyc("R4 clash while disabled", 5'b00000);

        tx_en = 1;
        cyc("R1 clash tx/ctl", 5'b00100);
        wr(1'b1, 2'b01);
        cyc("R9 irq lags ie write", 5'b00100);
        wr_en = 0;
        cyc("R9 irq from sa", 5'b10100);

        slots(1, 5'd3, 1, 5'd4, 1, 5'd5);
        wr(1'b0, 2'b00);
        cyc("R5 write zero keeps", 5'b10100);
        wr(1'b0, 2'b01);
        cyc("R3 clear restores tx gate", 5'b10010);
        wr_en = 0;
        cyc("R9 irq drops", 5'b00010);

        slots(1, 5'd3, 1, 5'd4, 1, 5'd4);
        wr(1'b0, 2'b01);
        cyc("R6 set beats clear", 5'b00100);
        wr_en = 0;
        slots(1, 5'd3, 1, 5'd4, 1, 5'd5);
        cyc("R6 flag held", 5'b10100);
        wr(1'b0, 2'b01);
        cyc("R5 clear sa", 5'b10010);
        wr_en = 0;
        rx_en = 1;
        cyc("R3 both gates open", 5'b00011);

        fsync = 1; frame_busy = 0;
        cyc("R7 fsync when idle", 5'b00011);
        fsync = 0;
        cyc("R7 no error", 5'b00011);
        fsync = 1; frame_busy = 1;
        cyc("R8 early fsync no gate", 5'b01011);
        wr(1'b0, 2'b10);
        cyc("R11 clear while fsync held", 5'b00011);
        wr_en = 0;
        cyc("R11 held fsync not recounted", 5'b00011);

        fsync = 0;
        wr(1'b1, 2'b10);
        cyc("R9 enable fs irq", 5'b00011);
        wr_en = 0;
        fsync = 1;
        cyc("R7 early fsync", 5'b01011);
        fsync = 0;
        cyc("R9 irq from fs", 5'b11011);

        tx_en = 0; rx_en = 0;
        wr(1'b0, 2'b10);
        cyc("R5 clear fs", 5'b10000);
        wr_en = 0;
        fsync = 1;
        cyc("R4 fsync while disabled", 5'b00000);
        fsync = 0;
        cyc("R4 still clear", 5'b00000);

        @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule